// File: doc/BRIEF.md
# Armed Masked-Trigger Capture Buffer

This block works like a small logic analyzer sitting behind several parallel 28-bit receive lanes. One new word arrives on every lane in every clock cycle. For each lane the host loads a match value and a compare mask. A mask bit of 1 means that bit is compared; a 0 means that bit is ignored. A single arm command starts all lanes together. Each lane then waits until its incoming word matches its masked pattern. It stores that word and the words that follow it, 256 consecutive words in all, in a private RAM, and then reports completion.

The host reaches everything through a byte-wide register port: commands, lane select, pattern and mask bytes, a status byte, and a captured-data window. Each read of the window returns the next byte of the selected lane's buffer and advances an internal read pointer.

Register map (4-bit address):

- 0x0: command on write (bit 0 arm, bit 1 clear); status on read.
- 0x1: lane select.
- 0x2: capture data window (read only).
- 0x4 to 0x7: pattern bytes of the selected lane.
- 0x8 to 0xB: mask bytes of the selected lane.
- Any other address reads as 0.

Top module: `trig_capture`

## Requirements
- R1: After reset all lanes are idle, the status byte (address 0x0) reads 0x00, host_rdata_o is 0x00, and every pattern and mask byte reads 0x00.
- R2: A lane in the waiting state triggers on the first sampled word w for which ((w XOR pattern) AND mask) is zero. A mask bit of 1 means that bit is compared.
- R3: Writing 1 to bit 0 of address 0x0 arms all four lanes in the same clock edge. A status read issued right after the arm write returns 1 in every armed bit.
- R4: The triggering word is stored at buffer entry 0. Entry k holds the word sampled k cycles after the trigger, for k up to 255.
- R5: After entry 255 is written the lane enters the done state. Status reads it as done=1 and armed=0. Done holds until the next arm or clear command, and a lane never becomes done without first capturing.
- R6: A lane whose pattern never matches stays armed with done=0 indefinitely.
- R7: An arm command received while a lane is waiting or capturing restarts that lane at entry 0 with its current pattern and mask.
- R8: Writing 1 to bit 1 of address 0x0 returns every lane to idle, which clears both the armed and done bits. When arm and clear are written together, clear wins.
- R9: Reads of address 0x2 return the selected lane's entries. Each entry is four bytes, least significant first; byte 3 carries word bits 27:24 in its low nibble with the upper nibble zero. The read pointer advances after byte 3. Writing the lane select (0x1) selects lane bits[1:0] and rewinds the pointer to entry 0, byte 0.
- R10: Pattern bytes (0x4 to 0x7, LSB first) and mask bytes (0x8 to 0xB) of the selected lane can be read back, and the upper nibble of byte 3 always reads 0. host_rdata_o is updated on the clock edge that samples host_re_i and holds its value otherwise.
- R11: The status byte is {done[3:0], armed[3:0]}, with lane n at bit n (armed) and bit 4+n (done). "Armed" covers both waiting and capturing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one receive word per lane per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 112 | Four 28-bit lane words, lane n at bits 28n+27:28n |
| host_addr_i | input | 4 | Register address |
| host_wdata_i | input | 8 | Write data byte |
| host_we_i | input | 1 | Write strobe, one cycle per write |
| host_re_i | input | 1 | Read strobe, one cycle per read |
| host_rdata_o | output | 8 | Registered read data |

## Verification
Commands take effect on the clock edge that samples host_we_i. Status therefore reflects an arm or clear at the very next read. host_rdata_o becomes valid one edge after the read strobe, so the bench raises the strobe at a falling edge, drops it at the next falling edge, and samples the data there. Capture timing is checked against a free-running bench counter that feeds every lane. A full-mask pattern set to a known future count pins entry 0 to an exact cycle. Each later entry must then equal its predecessor plus one. Completion is checked only after the pattern's count plus 256 cycles plus a margin.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;
  localparam int unsigned CAP_LANES  = 4;
  localparam int unsigned CAP_WORD_W = 28;
  localparam int unsigned CAP_DEPTH  = 256;

  localparam logic [3:0] A_CMD  = 4'h0;
  localparam logic [3:0] A_SEL  = 4'h1;
  localparam logic [3:0] A_DATA = 4'h2;

  typedef enum logic [1:0] {
    LS_IDLE,
    LS_WAIT,
    LS_CAPT,
    LS_DONE
  } lane_state_e;
endpackage

// File: rtl/tcap_match.sv
module tcap_match #(
  parameter int unsigned W = 28
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] pattern_i,
  input  logic [W-1:0] care_i,
  output logic         hit_o
);
  assign hit_o = ~|((data_i ^ pattern_i) & care_i);
endmodule

// File: rtl/tcap_lane.sv
module tcap_lane
  import trig_cap_pkg::*;
#(
  parameter int unsigned W     = 28,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          clr_i,
  input  logic [W-1:0]  rx_data_i,
  input  logic [W-1:0]  pattern_i,
  input  logic [W-1:0]  care_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  output logic          armed_o,
  output logic          done_o
);
  lane_state_e   state_q;
  logic [AW-1:0] wr_addr_q;
  logic          hit;
  logic          wr_en;
  logic [W-1:0]  mem [DEPTH];

  tcap_match #(.W(W)) u_match (
    .data_i   (rx_data_i),
    .pattern_i(pattern_i),
    .care_i   (care_i),
    .hit_o    (hit)
  );

  // commands override any capture in the same cycle
  assign wr_en = !arm_i && !clr_i &&
                 ((state_q == LS_WAIT && hit) || state_q == LS_CAPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LS_IDLE;
      wr_addr_q <= '0;
    end else if (clr_i) begin
      state_q   <= LS_IDLE;
      wr_addr_q <= '0;
    end else if (arm_i) begin
      state_q   <= LS_WAIT;
      wr_addr_q <= '0;
    end else begin
      unique case (state_q)
        LS_WAIT: if (hit) begin
          state_q   <= LS_CAPT;
          wr_addr_q <= wr_addr_q + 1'b1;
        end
        LS_CAPT: begin
          wr_addr_q <= wr_addr_q + 1'b1;
          if (wr_addr_q == AW'(DEPTH - 1)) state_q <= LS_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wr_addr_q] <= rx_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];
  assign armed_o   = (state_q == LS_WAIT) || (state_q == LS_CAPT);
  assign done_o    = (state_q == LS_DONE);
endmodule

// File: rtl/tcap_host_regs.sv
module tcap_host_regs
  import trig_cap_pkg::*;
#(
  parameter int unsigned NL   = 4,
  parameter int unsigned W    = 28,
  parameter int unsigned AW   = 8,
  localparam int unsigned LW  = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [3:0]           addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 we_i,
  input  logic                 re_i,
  output logic [7:0]           rdata_o,
  output logic                 arm_o,
  output logic                 clr_o,
  output logic [NL-1:0][W-1:0] pat_o,
  output logic [NL-1:0][W-1:0] care_o,
  output logic [AW-1:0]        rd_addr_o,
  input  logic [NL-1:0][W-1:0] cap_words_i,
  input  logic [2*NL-1:0]      status_i
);
  logic [7:0]           sel_q;
  logic [LW-1:0]        lane;
  logic [NL-1:0][W-1:0] pat_q, care_q;
  logic [AW-1:0]        ptr_q;
  logic [1:0]           byte_q;
  logic [7:0]           rdata_q;
  logic [W-1:0]         pat_nxt, care_nxt;
  logic [31:0]          pat_ext, care_ext, word_ext;
  logic [7:0]           rd_byte;
  logic                 wr_cmd, wr_pat, wr_care;

  assign lane    = sel_q[LW-1:0];
  assign wr_cmd  = we_i && (addr_i == A_CMD);
  assign wr_pat  = we_i && (addr_i[3:2] == 2'b01);
  assign wr_care = we_i && (addr_i[3:2] == 2'b10);
  assign arm_o   = wr_cmd && wdata_i[0];
  assign clr_o   = wr_cmd && wdata_i[1];

  // byte merge, bit by bit so widths under 32 need no padding
  always_comb begin
    pat_nxt  = pat_q[lane];
    care_nxt = care_q[lane];
    for (int j = 0; j < int'(W); j++) begin
      if (addr_i[1:0] == 2'(j / 8)) begin
        pat_nxt[j]  = wdata_i[j % 8];
        care_nxt[j] = wdata_i[j % 8];
      end
    end
  end

  assign pat_ext  = 32'(pat_q[lane]);
  assign care_ext = 32'(care_q[lane]);
  assign word_ext = 32'(cap_words_i[lane]);

  always_comb begin
    rd_byte = 8'h00;
    if (addr_i == A_CMD)       rd_byte = 8'(status_i);
    else if (addr_i == A_SEL)  rd_byte = sel_q;
    else if (addr_i == A_DATA) rd_byte = word_ext[8*byte_q +: 8];
    else if (addr_i[3:2] == 2'b01) rd_byte = pat_ext[8*addr_i[1:0] +: 8];
    else if (addr_i[3:2] == 2'b10) rd_byte = care_ext[8*addr_i[1:0] +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      pat_q   <= '0;
      care_q  <= '0;
      ptr_q   <= '0;
      byte_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i && addr_i == A_SEL) begin
        sel_q  <= wdata_i;
        ptr_q  <= '0;
        byte_q <= '0;
      end else if (re_i && addr_i == A_DATA) begin
        byte_q <= byte_q + 1'b1;
        if (byte_q == 2'd3) ptr_q <= ptr_q + 1'b1;
      end
      if (wr_pat)  pat_q[lane]  <= pat_nxt;
      if (wr_care) care_q[lane] <= care_nxt;
      if (re_i)    rdata_q      <= rd_byte;
    end
  end

  assign rdata_o   = rdata_q;
  assign pat_o     = pat_q;
  assign care_o    = care_q;
  assign rd_addr_o = ptr_q;
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_cap_pkg::*;
#(
  parameter int unsigned NUM_LANES = CAP_LANES,
  parameter int unsigned WORD_W    = CAP_WORD_W,
  parameter int unsigned DEPTH     = CAP_DEPTH
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LANES*WORD_W-1:0] rx_data_i,
  input  logic [3:0]                  host_addr_i,
  input  logic [7:0]                  host_wdata_i,
  input  logic                        host_we_i,
  input  logic                        host_re_i,
  output logic [7:0]                  host_rdata_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic                               arm_cmd, clr_cmd;
  logic [NUM_LANES-1:0]               lane_armed, lane_done;
  logic [NUM_LANES-1:0][WORD_W-1:0]   pat, care, cap_words;
  logic [AW-1:0]                      rd_addr;

  tcap_host_regs #(.NL(NUM_LANES), .W(WORD_W), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .we_i       (host_we_i),
    .re_i       (host_re_i),
    .rdata_o    (host_rdata_o),
    .arm_o      (arm_cmd),
    .clr_o      (clr_cmd),
    .pat_o      (pat),
    .care_o     (care),
    .rd_addr_o  (rd_addr),
    .cap_words_i(cap_words),
    .status_i   ({lane_done, lane_armed})
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    tcap_lane #(.W(WORD_W), .DEPTH(DEPTH)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arm_i    (arm_cmd),
      .clr_i    (clr_cmd),
      .rx_data_i(rx_data_i[g*WORD_W +: WORD_W]),
      .pattern_i(pat[g]),
      .care_i   (care[g]),
      .rd_addr_i(rd_addr),
      .rd_data_o(cap_words[g]),
      .armed_o  (lane_armed[g]),
      .done_o   (lane_done[g])
    );
  end
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
  parameter int unsigned NL = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          arm_cmd,
  input logic          clr_cmd,
  input logic [NL-1:0] lane_armed,
  input logic [NL-1:0] lane_done,
  input logic          host_re_i,
  input logic [7:0]    host_rdata_o
);
  p_arm_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_cmd && !clr_cmd) |=> (lane_armed == '1 && lane_done == '0));

  p_clear_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> ((lane_armed | lane_done) == '0));

  p_state_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lane_armed & lane_done) == '0));

  p_done_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_cmd && !clr_cmd) |=> ((lane_done & $past(lane_done)) == $past(lane_done)));

  p_done_after_capt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lane_done & ~$past(lane_done) & ~$past(lane_armed)) == '0));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_re_i |=> $stable(host_rdata_o));
endmodule

bind trig_capture trig_capture_chk #(.NL(NUM_LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arm_cmd     (arm_cmd),
  .clr_cmd     (clr_cmd),
  .lane_armed  (lane_armed),
  .lane_done   (lane_done),
  .host_re_i   (host_re_i),
  .host_rdata_o(host_rdata_o)
);

// File: tb/trig_capture_bench.sv
module trig_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int WD_CYCLES = 150000;

  // lane config table: pattern, mask, pattern relative to base, expected to hit
  localparam logic [27:0] TBL_PAT  [NL] = '{28'h0000000, 28'h1000009, 28'h0000000, 28'h0000000};
  localparam logic [27:0] TBL_MASK [NL] = '{28'hFFFFFFF, 28'h000000F, 28'h0000000, 28'hFFFFFFF};
  localparam bit          TBL_REL  [NL] = '{1'b1, 1'b0, 1'b0, 1'b1};
  localparam bit          TBL_HIT  [NL] = '{1'b1, 1'b1, 1'b1, 1'b0};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic         host_we = 1'b0;
  logic         host_re = 1'b0;
  logic [7:0]   host_rdata;
  logic [23:0]  tick;
  logic [NL*28-1:0] rx_flat;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= '0;
    else        tick <= tick + 1'b1;

  for (genvar g = 0; g < NL; g++) begin : g_rx
    assign rx_flat[g*28 +: 28] = {4'(g), tick};
  end

  trig_capture u_trig_capture (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_data_i   (rx_flat),
    .host_addr_i (host_addr),
    .host_wdata_i(host_wdata),
    .host_we_i   (host_we),
    .host_re_i   (host_re),
    .host_rdata_o(host_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_re = 1'b1;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic set_lane(input int ln, input logic [27:0] p, input logic [27:0] m);
    logic [31:0] pe, me;
    pe = {4'h0, p};
    me = {4'h0, m};
    host_wr(4'h1, 8'(ln));
    for (int b = 0; b < 4; b++) begin
      host_wr(4'(4 + b), pe[8*b +: 8]);
      host_wr(4'(8 + b), me[8*b +: 8]);
    end
  endtask

  task automatic read_word(output logic [31:0] w);
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      host_rd(4'h2, d);
      w[8*b +: 8] = d;
    end
  endtask

  task automatic wait_tick(input logic [23:0] t);
    while (tick < t) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_CYCLES, WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [31:0] w, prev;
    logic [23:0] base, b1, b2;
    logic [27:0] cfg_pat [NL];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 rdata", 32'(host_rdata), 32'h0);
    host_rd(4'h0, d); check("R1 status", 32'(d), 32'h0);
    host_rd(4'h4, d); check("R1 pattern byte", 32'(d), 32'h0);
    host_rd(4'hB, d); check("R1 mask byte", 32'(d), 32'h0);

    // walk lane config table
    base = tick + 24'd400;
    for (int i = 0; i < NL; i++) begin
      cfg_pat[i] = TBL_REL[i] ? {TBL_PAT[i][27:24], TBL_PAT[i][23:0] + base} : TBL_PAT[i];
      set_lane(i, cfg_pat[i], TBL_MASK[i]);
    end

    // R10 readback, byte 3 upper nibble ignored
    host_wr(4'h1, 8'h00);
    host_wr(4'hB, 8'hFF);
    host_rd(4'hB, d); check("R10 mask byte3 nibble", 32'(d), 32'h0F);
    for (int b = 0; b < 4; b++) begin
      w = {4'h0, cfg_pat[0]};
      host_rd(4'(4 + b), d); check("R10 pattern readback", 32'(d), 32'(w[8*b +: 8]));
    end
    host_rd(4'h1, d); check("R9 select readback", 32'(d), 32'h0);

    // R3 arm all, R11 status layout
    host_wr(4'h0, 8'h01);
    host_rd(4'h0, d); check("R3 R11 armed after arm", 32'(d), 32'h0F);

    wait_tick(base + 24'd300);
    host_rd(4'h0, d); check("R5 R6 R11 status after capture", 32'(d), 32'h78);

    for (int i = 0; i < NL; i++) begin
      if (!TBL_HIT[i]) continue;
      host_wr(4'h1, 8'(i));
      prev = '0;
      for (int k = 0; k < 256; k++) begin
        read_word(w);
        if (k == 0) begin
          check("R2 masked match", w & {4'h0, TBL_MASK[i]}, {4'h0, cfg_pat[i] & TBL_MASK[i]});
          if (i == 0) check("R4 entry0 exact", w, {4'h0, cfg_pat[0]});
        end else begin
          check("R4 R9 consecutive entry", w, {4'h0, 4'(i), prev[23:0] + 24'd1});
        end
        prev = w;
      end
    end

    // R9 rewind by select write
    host_wr(4'h1, 8'h00);
    read_word(w); check("R9 rewind entry0", w, {4'h0, cfg_pat[0]});

    // R8 clear
    host_wr(4'h0, 8'h02);
    host_rd(4'h0, d); check("R8 clear to idle", 32'(d), 32'h0);

    // R7 rearm during capture
    b1 = tick + 24'd60;
    set_lane(0, {4'h0, b1}, 28'hFFFFFFF);
    host_wr(4'h0, 8'h01);
    wait_tick(b1 + 24'd30);
    host_rd(4'h0, d); check("R7 capturing shows armed", 32'({d[4], d[0]}), 32'h1);
    b2 = tick + 24'd60;
    set_lane(0, {4'h0, b2}, 28'hFFFFFFF);
    host_wr(4'h0, 8'h01);
    host_rd(4'h0, d); check("R7 rearmed not done", 32'({d[4], d[0]}), 32'h1);
    wait_tick(b2 + 24'd280);
    host_rd(4'h0, d); check("R7 R5 done after restart", 32'({d[4], d[0]}), 32'h2);
    host_wr(4'h1, 8'h00);
    for (int k = 0; k < 256; k++) begin
      read_word(w);
      check("R7 restarted entry", w, {8'h00, b2 + 24'(k)});
    end

    // R8 arm and clear together
    host_wr(4'h0, 8'h03);
    host_rd(4'h0, d); check("R8 clear wins over arm", 32'(d), 32'h0);
    repeat (5) @(negedge clk);
    host_rd(4'h0, d); check("R8 stays idle", 32'(d), 32'h0);

    summary();
    $finish;
  end
endmodule